// File: doc/BRIEF.md
# CAN Fault Confinement Unit

This block tracks how healthy a CAN node is on the bus. The protocol engine sends it one-cycle event pulses: transmit error, receive error, transmit success and receive success. The block keeps a transmit error count and a receive error count and updates both from these pulses. From the two counts it picks one of three node states: error active, error passive or bus off. The node may stay on the bus in the first two states. In bus off it must stay silent.

Once the node is in bus off, the block watches the sampled bus bits. It counts runs of eleven recessive bits in a row. A dominant bit starts the current run again. When enough runs have been seen, the node goes back to error active and both counts return to zero.

Both counts and the passive and bus-off flags are outputs. Any change of either flag can latch a pending interrupt. The interrupt enable input gates this, and software clears the pending bit with a one-cycle acknowledge pulse.

Top module: `can_fault_conf`

## Requirements
- R1: After reset, tec_o and rec_o are 0, passive_o and bus_off_o are 0, and irq_o is 0.
- R2: Outside bus off, a cycle with tx_err_i high adds 8 to tec_o, saturating at 511. A cycle with tx_ok_i high and tx_err_i low subtracts 1 from tec_o, never going below 0. Every update shows on the outputs one cycle after the input cycle.
- R3: Outside bus off, rx_err_i high adds 1 to rec_o, saturating at 255 so the count never wraps. rx_ok_i high with rx_err_i low subtracts 1 from rec_o, never going below 0.
- R4: When either count exceeds 127 and the transmit count is at most 255, passive_o reads 1 in the same cycle as the new count values.
- R5: When both counts are below 128, passive_o reads 0 again and the node is error active.
- R6: When the transmit count exceeds 255, bus_off_o reads 1 and passive_o reads 0.
- R7: While bus_off_o is 1, error and success pulses have no effect, and tec_o and rec_o hold their values.
- R8: In bus off, each cycle with bit_valid_i high samples one bus bit. bit_rec_i = 1 means recessive and 0 means dominant. Eleven recessive samples in a row complete one run, and a dominant sample starts the current run again without losing runs already completed. The 128th completed run clears tec_o, rec_o and bus_off_o on the next cycle.
- R9: A change of passive_o or bus_off_o while irq_en_i is 1 sets irq_o in the same cycle as the flag change. irq_o stays at 1 until a cycle with irq_clr_i high and no new change. A new change wins over a clear in the same cycle.
- R10: A flag change while irq_en_i is 0 does not set irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_err_i | input | 1 | Transmit error pulse |
| tx_ok_i | input | 1 | Successful transmit pulse |
| rx_err_i | input | 1 | Receive error pulse |
| rx_ok_i | input | 1 | Successful receive pulse |
| bit_valid_i | input | 1 | Bus bit sample strobe |
| bit_rec_i | input | 1 | Sampled bit level, 1 = recessive |
| irq_en_i | input | 1 | Status interrupt enable |
| irq_clr_i | input | 1 | Pending interrupt acknowledge pulse |
| tec_o | output | 9 | Transmit error count |
| rec_o | output | 8 | Receive error count |
| passive_o | output | 1 | Error passive flag |
| bus_off_o | output | 1 | Bus off flag |
| irq_o | output | 1 | Pending status interrupt |

## Verification
The hardest place to reach is the end of bus off recovery. It needs 1408 recessive samples with no errors, and a single dominant sample must restart only the current run. The stimulus first drives 32 transmit errors to reach bus off. It then fires event pulses that must be ignored, then sends ten recessive samples and one dominant sample. After that it counts out the recessive samples one by one and checks the cycle just before release and the cycle of release. A long random phase with a high transmit error rate and mostly recessive bits then drives the node through bus off and recovery many more times.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'd0,
    FC_PASSIVE = 2'd1,
    FC_BUS_OFF = 2'd2
  } fc_state_e;
endpackage

// File: rtl/can_fc_err_cnt.sv
module can_fc_err_cnt #(
  parameter int unsigned W   = 8,
  parameter int unsigned INC = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         freeze_i,
  input  logic         clear_i,
  input  logic         err_i,
  input  logic         ok_i,
  output logic [W-1:0] cnt_q_o,
  output logic [W-1:0] cnt_d_o
);
  localparam logic [W-1:0] MAX_V  = {W{1'b1}};
  localparam logic [W-1:0] INC_V  = W'(INC);
  localparam logic [W-1:0] HEAD_V = MAX_V - INC_V;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (!freeze_i) begin
      if (err_i)
        cnt_d = (cnt_q > HEAD_V) ? MAX_V : cnt_q + INC_V;
      else if (ok_i && cnt_q != '0)
        cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_q_o = cnt_q;
  assign cnt_d_o = cnt_d;

  p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_i && !clear_i) |=> $stable(cnt_q));
  p_cnt_nowrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == MAX_V && !clear_i) |=> cnt_q != '0);
  p_cnt_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> cnt_q == '0);
endmodule

// File: rtl/can_fc_recovery.sv
module can_fc_recovery #(
  parameter int unsigned RUN_BITS = 11,
  parameter int unsigned RUNS     = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic bit_valid_i,
  input  logic bit_rec_i,
  output logic done_o
);
  localparam int BW = (RUN_BITS > 1) ? $clog2(RUN_BITS) : 1;
  localparam int RW = (RUNS > 1) ? $clog2(RUNS) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(RUN_BITS - 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(RUNS - 1);

  logic [BW-1:0] bit_cnt_q;
  logic [RW-1:0] run_cnt_q;
  logic          bit_last, run_last;

  assign bit_last = (bit_cnt_q == BIT_LAST);
  assign run_last = (run_cnt_q == RUN_LAST);
  assign done_o   = arm_i & bit_valid_i & bit_rec_i & bit_last & run_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      run_cnt_q <= '0;
    end else if (!arm_i) begin
      bit_cnt_q <= '0;
      run_cnt_q <= '0;
    end else if (bit_valid_i) begin
      if (!bit_rec_i) begin
        bit_cnt_q <= '0;  // dominant bit restarts the run only
      end else if (bit_last) begin
        bit_cnt_q <= '0;
        run_cnt_q <= run_last ? '0 : run_cnt_q + 1'b1;
      end else begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
    end
  end

  p_dom_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && bit_valid_i && !bit_rec_i) |=> bit_cnt_q == '0);
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !bit_valid_i) |=> ($stable(bit_cnt_q) && $stable(run_cnt_q)));
endmodule

// File: rtl/can_fc_state.sv
module can_fc_state
  import can_fc_pkg::*;
#(
  parameter int unsigned TEC_W       = 9,
  parameter int unsigned REC_W       = 8,
  parameter int unsigned PASSIVE_LIM = 127,
  parameter int unsigned BOFF_LIM    = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TEC_W-1:0] tec_i,
  input  logic [REC_W-1:0] rec_i,
  input  logic [TEC_W-1:0] tec_d_i,
  input  logic [REC_W-1:0] rec_d_i,
  input  logic             recover_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic             passive_o,
  output logic             bus_off_o,
  output logic             irq_o
);
  localparam logic [TEC_W-1:0] TEC_PAS_V = TEC_W'(PASSIVE_LIM);
  localparam logic [REC_W-1:0] REC_PAS_V = REC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_OFF_V = TEC_W'(BOFF_LIM);

  fc_state_e state_q, state_d;
  logic      passive_d, boff_d, flag_chg, irq_q, irq_d;

  always_comb begin
    state_d = state_q;
    if (state_q == FC_BUS_OFF) begin
      if (recover_i) state_d = FC_ACTIVE;
    end else if (tec_d_i > TEC_OFF_V) begin
      state_d = FC_BUS_OFF;
    end else if (tec_d_i > TEC_PAS_V || rec_d_i > REC_PAS_V) begin
      state_d = FC_PASSIVE;
    end else begin
      state_d = FC_ACTIVE;
    end
  end

  assign passive_d = (state_d == FC_PASSIVE);
  assign boff_d    = (state_d == FC_BUS_OFF);
  assign passive_o = (state_q == FC_PASSIVE);
  assign bus_off_o = (state_q == FC_BUS_OFF);
  assign flag_chg  = (passive_d != passive_o) || (boff_d != bus_off_o);

  always_comb begin
    irq_d = irq_q;
    if (flag_chg && irq_en_i) irq_d = 1'b1;
    else if (irq_clr_i)       irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FC_ACTIVE;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
    end
  end

  assign irq_o = irq_q;

  p_passive_thresh_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    passive_o |-> (tec_i > TEC_PAS_V || rec_i > REC_PAS_V));
  p_active_thresh_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!passive_o && !bus_off_o) |-> (tec_i <= TEC_PAS_V && rec_i <= REC_PAS_V));
  p_boff_thresh_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_off_o |-> (tec_i > TEC_OFF_V && !passive_o));
  p_boff_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_off_o) |-> (tec_i == '0 && rec_i == '0));
  p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
  p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !irq_en_i) |=> !irq_o);
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
  parameter int unsigned TEC_W       = 9,
  parameter int unsigned REC_W       = 8,
  parameter int unsigned TX_STEP     = 8,
  parameter int unsigned RX_STEP     = 1,
  parameter int unsigned PASSIVE_LIM = 127,
  parameter int unsigned BOFF_LIM    = 255,
  parameter int unsigned RUN_BITS    = 11,
  parameter int unsigned RUNS_NEEDED = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_err_i,
  input  logic             rx_ok_i,
  input  logic             bit_valid_i,
  input  logic             bit_rec_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic             passive_o,
  output logic             bus_off_o,
  output logic             irq_o
);
  logic [TEC_W-1:0] tec_d;
  logic [REC_W-1:0] rec_d;
  logic             recover, boff;

  can_fc_err_cnt #(.W(TEC_W), .INC(TX_STEP)) u_tec (
    .clk_i, .rst_ni, .freeze_i(boff), .clear_i(recover),
    .err_i(tx_err_i), .ok_i(tx_ok_i), .cnt_q_o(tec_o), .cnt_d_o(tec_d)
  );

  can_fc_err_cnt #(.W(REC_W), .INC(RX_STEP)) u_rec (
    .clk_i, .rst_ni, .freeze_i(boff), .clear_i(recover),
    .err_i(rx_err_i), .ok_i(rx_ok_i), .cnt_q_o(rec_o), .cnt_d_o(rec_d)
  );

  can_fc_recovery #(.RUN_BITS(RUN_BITS), .RUNS(RUNS_NEEDED)) u_recov (
    .clk_i, .rst_ni, .arm_i(boff), .bit_valid_i, .bit_rec_i, .done_o(recover)
  );

  can_fc_state #(
    .TEC_W(TEC_W), .REC_W(REC_W), .PASSIVE_LIM(PASSIVE_LIM), .BOFF_LIM(BOFF_LIM)
  ) u_state (
    .clk_i, .rst_ni, .tec_i(tec_o), .rec_i(rec_o), .tec_d_i(tec_d), .rec_d_i(rec_d),
    .recover_i(recover), .irq_en_i, .irq_clr_i,
    .passive_o, .bus_off_o(boff), .irq_o
  );

  assign bus_off_o = boff;
endmodule

// File: tb/can_fault_conf_tb.sv
`timescale 1ns/1ps
module can_fault_conf_tb;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_err, tx_ok, rx_err, rx_ok, bit_valid, bit_rec, irq_en, irq_clr;
  logic [8:0] tec_o;
  logic [7:0] rec_o;
  logic passive_o, bus_off_o, irq_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  int m_tec, m_rec, m_st, m_bits, m_runs;
  bit m_pend;

  always #10 clk = ~clk;

  can_fault_conf u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tx_err_i(tx_err), .tx_ok_i(tx_ok),
    .rx_err_i(rx_err), .rx_ok_i(rx_ok), .bit_valid_i(bit_valid), .bit_rec_i(bit_rec),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr), .tec_o(tec_o), .rec_o(rec_o),
    .passive_o(passive_o), .bus_off_o(bus_off_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 tec_o", int'(tec_o), m_tec);
    chk("R3 rec_o", int'(rec_o), m_rec);
    chk("R4 passive_o", int'(passive_o), int'(m_st == 1));
    chk("R6 bus_off_o", int'(bus_off_o), int'(m_st == 2));
    chk("R9 irq_o", int'(irq_o), int'(m_pend));
  endtask

  task automatic idle_inputs();
    tx_err = 0; tx_ok = 0; rx_err = 0; rx_ok = 0;
    bit_valid = 0; bit_rec = 1; irq_clr = 0;
  endtask

  task automatic model_step();
    int ntec = m_tec, nrec = m_rec, nst = m_st;
    bit chg;
    if (m_st == 2) begin
      if (bit_valid) begin
        if (!bit_rec) m_bits = 0;
        else if (m_bits == 10) begin
          m_bits = 0;
          if (m_runs == 127) begin ntec = 0; nrec = 0; nst = 0; m_runs = 0; end
          else m_runs++;
        end else m_bits++;
      end
    end else begin
      if (tx_err) ntec = (ntec + 8 > 511) ? 511 : ntec + 8;
      else if (tx_ok && ntec > 0) ntec--;
      if (rx_err) nrec = (nrec + 1 > 255) ? 255 : nrec + 1;
      else if (rx_ok && nrec > 0) nrec--;
      if (ntec > 255) nst = 2;
      else if (ntec > 127 || nrec > 127) nst = 1;
      else nst = 0;
      m_bits = 0; m_runs = 0;
    end
    chg = ((nst == 1) != (m_st == 1)) || ((nst == 2) != (m_st == 2));
    if (chg && irq_en) m_pend = 1;
    else if (irq_clr) m_pend = 0;
    m_tec = ntec; m_rec = nrec; m_st = nst;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    idle_inputs();
    m_tec = 0; m_rec = 0; m_st = 0; m_bits = 0; m_runs = 0; m_pend = 0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1;
    chk("R1 reset tec_o", int'(tec_o), 0);
    chk("R1 reset rec_o", int'(rec_o), 0);
    chk("R1 reset flags", int'({passive_o, bus_off_o, irq_o}), 0);
  endtask

  task automatic rand_inputs(int txe_pct, int bv_pct);
    tx_err    = ($urandom % 100) < txe_pct;
    tx_ok     = ($urandom % 100) < 40;
    rx_err    = ($urandom % 100) < 30;
    rx_ok     = ($urandom % 100) < 30;
    bit_valid = ($urandom % 100) < bv_pct;
    bit_rec   = ($urandom % 64) != 0;
    irq_en    = ($urandom % 8) != 0;
    irq_clr   = ($urandom % 16) == 0;
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    irq_en = 0;
    idle_inputs();
    do_reset();

    // R10: gated change, then R4 entry to passive
    irq_en = 0; rx_err = 1;
    repeat (128) tick();
    chk("R4 passive after rec 128", int'(passive_o), 1);
    chk("R10 irq gated", int'(irq_o), 0);
    chk("R3 rec at 128", int'(rec_o), 128);
    // R5 back to active, R9 irq latched
    irq_en = 1; rx_err = 0; rx_ok = 1;
    tick();
    chk("R5 passive cleared", int'(passive_o), 0);
    chk("R9 irq set on change", int'(irq_o), 1);
    // R3 saturation
    rx_ok = 0; rx_err = 1;
    repeat (300) tick();
    chk("R3 rec saturates", int'(rec_o), 255);
    // R9 clear
    rx_err = 0; irq_clr = 1;
    tick();
    irq_clr = 0;
    chk("R9 irq cleared", int'(irq_o), 0);

    for (int i = 0; i < 2000; i++) begin rand_inputs(12, 50); tick(); end

    // R6 entry to bus off
    do_reset();
    irq_en = 1; tx_err = 1;
    repeat (32) tick();
    chk("R6 bus off", int'(bus_off_o), 1);
    chk("R6 passive low", int'(passive_o), 0);
    chk("R2 tec 256", int'(tec_o), 256);
    // R7 events ignored
    for (int i = 0; i < 50; i++) begin
      rand_inputs(50, 0);
      irq_clr = 0;
      tick();
    end
    chk("R7 tec held", int'(tec_o), 256);
    chk("R7 rec held", int'(rec_o), 0);
    idle_inputs();
    // R8 recovery with one dominant restart
    bit_valid = 1; bit_rec = 1;
    repeat (10) tick();
    bit_rec = 0; tick();
    bit_rec = 1;
    repeat (128 * 11 - 1) tick();
    chk("R8 still bus off", int'(bus_off_o), 1);
    tick();
    chk("R8 released", int'(bus_off_o), 0);
    chk("R8 tec cleared", int'(tec_o), 0);
    idle_inputs();

    for (int i = 0; i < 6000; i++) begin rand_inputs(35, 85); tick(); end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule